// File: doc/BRIEF.md
# Bidirectional Handshake Port Controller

This block runs one parallel port whose pins carry traffic in both directions. A host on a small register bus writes bytes into an output latch. The host also reads bytes that a peripheral has captured into a separate input latch. Five upper lines of the auxiliary control port carry the handshake. The peripheral pulses an active-low strobe to hand a byte in. It pulls an active-low acknowledge to take a byte out, and the port drives its pins only while that acknowledge is low. A buffer-full flag reports each direction. A single interrupt request merges the two directions. Each direction has its own enable flip-flop, and the host sets or clears those enables with single-bit set/reset words written to the control address.

The host polls a status byte on the auxiliary-port address. In that byte the handshake flags sit at the bit positions of their pins, and the two enable flags take the places of the strobe and acknowledge pins. The three low auxiliary lines, and the second data port, belong to a neighbouring port's logic. This block only passes the low three status bits through from that logic. The host bus is a plain register strobe interface with no back-pressure. Every access completes in the cycle it is presented, and flow control is done by polling the flags or by taking the interrupt.

Top module: `bdir_port_ctrl`

## Requirements
- R1: After reset, obf_n is 1, ibf is 0, intr is 0, both interrupt enables are 0, and pa_oe is 0 while ack_n is high.
- R2: A host write to select 0 loads bus_wdata into the output latch, and obf_n is 0 from the next cycle.
- R3: pa_oe is 1 exactly while ack_n is low, and during that time pa_out carries the most recent byte the host wrote.
- R4: A falling edge on ack_n releases obf_n to 1. pa_out keeps the output latch content afterwards.
- R5: A falling edge on stb_n copies pa_in into the input latch and sets ibf. The output latch is not changed.
- R6: A host read of select 0 returns the input latch on bus_rdata in the same cycle, and clears ibf at the clock edge.
- R7: A control write (select 3) with bit 7 equal to 0 is a set/reset word. Bits 3:1 pick the line, and bit 0 is the new value. Line 6 writes the output interrupt enable and line 4 writes the input interrupt enable. Any other line leaves this block's state unchanged.
- R8: intr is 1 when ibf is set with the input enable on, or when the output side is done with the output enable on. The output side becomes done at the rising edge of ack_n that follows a release, and it stops being done at the next host write to select 0.
- R9: A host read of select 2 returns a status byte. Bit 7 is obf_n, bit 6 is the output enable, bit 5 is ibf, bit 4 is the input enable, bit 3 is intr, and bits 2:0 are pc_lo_in.
- R10: A control write with bit 7 equal to 1 (a mode word) clears both enables, ibf and the done state, and sets obf_n to 1.
- R11: A strobe that arrives while ibf is already set overwrites the input latch, and ibf stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select: 0 data, 2 status, 3 control |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Host read data (combinational from bus_sel) |
| pa_in | input | DATA_W | Port pin values seen from outside |
| pa_out | output | DATA_W | Port pin values to drive |
| pa_oe | output | 1 | Port pin drive enable; pins float when 0 |
| stb_n | input | 1 | Active-low input strobe (line 4) |
| ack_n | input | 1 | Active-low output acknowledge (line 6) |
| obf_n | output | 1 | Active-low output buffer full (line 7) |
| ibf | output | 1 | Input buffer full (line 5) |
| intr | output | 1 | Shared interrupt request (line 3) |
| pc_lo_in | input | 3 | Low auxiliary lines from the neighbouring port logic |

## Verification
The assertions assume a few things about the inputs. Each stb_n and ack_n pulse stays low, and then high, for longer than the synchronizer depth plus one cycle, so every edge is seen once. pa_in is stable while stb_n is low. At most one of bus_wr and bus_rd is high in any cycle. The stimulus holds every pin level for six cycles and presents pa_in together with the strobe. It also issues each host access as a single one-cycle strobe, so the edge-cause checks on obf_n, ibf and the enables only see causes that the bench created.

// File: rtl/bdir_port_pkg.sv
package bdir_port_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_AUX  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTRL = 2'd3
  } bus_sel_e;

  localparam int unsigned LINE_INTR = 3;
  localparam int unsigned LINE_STB  = 4;
  localparam int unsigned LINE_IBF  = 5;
  localparam int unsigned LINE_ACK  = 6;
  localparam int unsigned LINE_OBF  = 7;

  // Status byte: handshake flags at their pin positions, enables on stb/ack slots.
  function automatic logic [7:0] pack_status(
    input logic       obf_n_v,
    input logic       ie_out_v,
    input logic       ibf_v,
    input logic       ie_in_v,
    input logic       intr_v,
    input logic [2:0] lo_v
  );
    logic [7:0] s;
    s           = '0;
    s[LINE_OBF] = obf_n_v;
    s[LINE_ACK] = ie_out_v;
    s[LINE_IBF] = ibf_v;
    s[LINE_STB] = ie_in_v;
    s[LINE_INTR]= intr_v;
    s[2:0]      = lo_v;
    return s;
  endfunction

endpackage

// File: rtl/bdp_edge_sync.sv
module bdp_edge_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic fall,
  output logic rise
);
  localparam int unsigned DEPTH = (STAGES < 1) ? 2 : STAGES + 1;

  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {DEPTH{IDLE_LEVEL}};
    else        chain <= {chain[DEPTH-2:0], din};
  end

  assign level = chain[DEPTH-2];
  assign fall  =  chain[DEPTH-1] & ~chain[DEPTH-2];
  assign rise  = ~chain[DEPTH-1] &  chain[DEPTH-2];
endmodule

// File: rtl/bdp_in_path.sv
module bdp_in_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stb_fall,
  input  logic [DATA_W-1:0] pin_data,
  input  logic              host_take,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (clr) begin
      full_q <= 1'b0;
    end else if (stb_fall) begin
      data_q <= pin_data;   // new byte wins over a same-cycle host read
      full_q <= 1'b1;
    end else if (host_take) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bdp_out_path.sv
module bdp_out_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              host_load,
  input  logic [DATA_W-1:0] host_data,
  input  logic              ack_fall,
  input  logic              ack_rise,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q,
  output logic              done_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      done_q <= 1'b0;
    end else if (clr) begin
      full_q <= 1'b0;
      done_q <= 1'b0;
    end else if (host_load) begin
      data_q <= host_data;  // a load wins over a same-cycle acknowledge edge
      full_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      if (ack_fall) full_q <= 1'b0;
      if (ack_rise && !full_q) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bdir_port_ctrl.sv
module bdir_port_ctrl
  import bdir_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pa_in,
  output logic [DATA_W-1:0] pa_out,
  output logic              pa_oe,
  input  logic              stb_n,
  input  logic              ack_n,
  output logic              obf_n,
  output logic              ibf,
  output logic              intr,
  input  logic [2:0]        pc_lo_in
);
  localparam int unsigned LINE_W = 3;

  logic stb_lvl, stb_fall, stb_rise;
  logic ack_lvl, ack_fall, ack_rise;
  logic ctrl_wr, mode_wr, bsr_wr, data_wr, data_rd;
  logic [LINE_W-1:0] bsr_line;
  logic inte_out_q, inte_in_q;
  logic [DATA_W-1:0] in_data, out_data;
  logic in_full, out_full, out_done;
  logic [7:0] status;

  bdp_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_stb_sync (
    .clk(clk), .rst_n(rst_n), .din(stb_n),
    .level(stb_lvl), .fall(stb_fall), .rise(stb_rise)
  );

  bdp_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .din(ack_n),
    .level(ack_lvl), .fall(ack_fall), .rise(ack_rise)
  );

  // Host decode
  assign ctrl_wr  = bus_wr && (bus_sel == SEL_CTRL);
  assign mode_wr  = ctrl_wr &&  bus_wdata[7];
  assign bsr_wr   = ctrl_wr && !bus_wdata[7];
  assign bsr_line = bus_wdata[3:1];
  assign data_wr  = bus_wr && (bus_sel == SEL_DATA);
  assign data_rd  = bus_rd && (bus_sel == SEL_DATA);

  // Interrupt enables, written by single-bit set/reset words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inte_out_q <= 1'b0;
      inte_in_q  <= 1'b0;
    end else if (mode_wr) begin
      inte_out_q <= 1'b0;
      inte_in_q  <= 1'b0;
    end else if (bsr_wr) begin
      if (bsr_line == LINE_W'(LINE_ACK)) inte_out_q <= bus_wdata[0];
      if (bsr_line == LINE_W'(LINE_STB)) inte_in_q  <= bus_wdata[0];
    end
  end

  bdp_in_path #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_n), .clr(mode_wr),
    .stb_fall(stb_fall), .pin_data(pa_in), .host_take(data_rd),
    .data_q(in_data), .full_q(in_full)
  );

  bdp_out_path #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .clr(mode_wr),
    .host_load(data_wr), .host_data(bus_wdata),
    .ack_fall(ack_fall), .ack_rise(ack_rise),
    .data_q(out_data), .full_q(out_full), .done_q(out_done)
  );

  // Pin side: drive gated directly by the acknowledge pin
  assign pa_out = out_data;
  assign pa_oe  = ~ack_n;
  assign obf_n  = ~out_full;
  assign ibf    = in_full;
  assign intr   = (in_full & inte_in_q) | (out_done & inte_out_q);

  assign status = pack_status(obf_n, inte_out_q, in_full, inte_in_q, intr, pc_lo_in);

  always_comb begin
    bus_rdata = '0;
    unique case (bus_sel)
      SEL_DATA: bus_rdata = in_data;
      SEL_STAT: bus_rdata = DATA_W'(status);
      default:  bus_rdata = '0;
    endcase
  end

  logic unused_lvl;
  assign unused_lvl = stb_lvl ^ ack_lvl ^ stb_rise;
endmodule

// File: rtl/bdir_port_chk.sv
module bdir_port_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_sel,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              obf_n,
  input logic              ibf,
  input logic              intr,
  input logic              inte_out_q,
  input logic              inte_in_q,
  input logic              ack_fall,
  input logic              stb_fall
);
  // R2
  load_sets_obf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd0) |=> !obf_n);

  // R4
  obf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obf_n) |-> ($past(ack_fall) || $past(bus_wr && bus_sel == 2'd3 && bus_wdata[7])));

  // R5
  ibf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibf) |-> $past(stb_fall));

  // R6
  ibf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ibf) |-> ($past(bus_rd && bus_sel == 2'd0) || $past(bus_wr && bus_sel == 2'd3 && bus_wdata[7])));

  // R7
  inte_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({inte_out_q, inte_in_q}) |-> $past(bus_wr && bus_sel == 2'd3));

  // R8
  intr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intr |-> ((ibf && inte_in_q) || (obf_n && inte_out_q)));
endmodule

bind bdir_port_ctrl bdir_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .obf_n(obf_n), .ibf(ibf), .intr(intr),
  .inte_out_q(inte_out_q), .inte_in_q(inte_in_q),
  .ack_fall(ack_fall), .stb_fall(stb_fall)
);

// File: tb/bdir_port_ctrl_bench.sv
module bdir_port_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pa_in = '0, pa_out;
  logic       pa_oe, stb_n = 1'b1, ack_n = 1'b1;
  logic       obf_n, ibf, intr;
  logic [2:0] pc_lo_in = 3'b101;

  int n_chk = 0, n_err = 0;
  logic [7:0] out_q[$];
  logic [7:0] in_q[$];
  logic m_obf_n = 1'b1, m_ibf = 1'b0, m_ie_out = 1'b0, m_ie_in = 1'b0, m_done = 1'b0;
  logic prev_oe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bdir_port_ctrl u_bdir_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pa_in(pa_in), .pa_out(pa_out),
    .pa_oe(pa_oe), .stb_n(stb_n), .ack_n(ack_n), .obf_n(obf_n), .ibf(ibf),
    .intr(intr), .pc_lo_in(pc_lo_in)
  );

  function automatic logic m_intr();
    return (m_ibf & m_ie_in) | (m_done & m_ie_out);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); #1;
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk); #1;
    bus_sel = sel; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); #1;
    bus_rd = 1'b0;
  endtask

  // Driver: output byte, expectation pushed for the monitor
  task automatic send_byte(input logic [7:0] d);
    out_q.push_back(d);
    host_write(2'd0, d);
    m_obf_n = 1'b0; m_done = 1'b0;
  endtask

  task automatic ack_pulse();
    @(negedge clk); #1;
    ack_n = 1'b0;
    #1 check("R3 oe while ack low", {7'd0, pa_oe}, 8'd1);
    repeat (HOLD) @(negedge clk);
    #1 ack_n = 1'b1;
    #1 check("R3 oe off after ack", {7'd0, pa_oe}, 8'd0);
    repeat (HOLD) @(negedge clk);
    m_obf_n = 1'b1; m_done = 1'b1;
  endtask

  task automatic strobe(input logic [7:0] d);
    @(negedge clk); #1;
    pa_in = d; stb_n = 1'b0;
    repeat (HOLD) @(negedge clk);
    #1 stb_n = 1'b1;
    repeat (HOLD) @(negedge clk);
    if (m_ibf) void'(in_q.pop_front());
    in_q.push_back(d);
    m_ibf = 1'b1;
  endtask

  task automatic take_byte(input string req);
    logic [7:0] d;
    logic [7:0] e;
    e = (in_q.size() > 0) ? in_q.pop_front() : 8'hxx;
    host_read(2'd0, d);
    check(req, d, e);
    m_ibf = 1'b0;
  endtask

  task automatic check_status(input string req);
    logic [7:0] d;
    host_read(2'd2, d);
    check(req, d, {m_obf_n, m_ie_out, m_ibf, m_ie_in, m_intr(), pc_lo_in});
  endtask

  task automatic check_pins(input string req);
    @(negedge clk);
    check({req, " obf_n"}, {7'd0, obf_n}, {7'd0, m_obf_n});
    check({req, " ibf"},   {7'd0, ibf},   {7'd0, m_ibf});
    check({req, " intr"},  {7'd0, intr},  {7'd0, m_intr()});
  endtask

  // Monitor: each new drive window must present the next expected byte (R3)
  always @(negedge clk) begin
    if (rst_n && pa_oe && !prev_oe) begin
      if (out_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R3: drive with no pending byte, actual %02h expected none", pa_out);
      end else begin
        check("R3 drive data", pa_out, out_q.pop_front());
      end
    end
    prev_oe = pa_oe;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check_pins("R1");
    check("R1 oe", {7'd0, pa_oe}, 8'd0);
    check_status("R1/R9 status after reset");

    // R2 load, R3 drive, R4 release
    send_byte(8'h5A);
    check_pins("R2");
    check_status("R9 status full");
    ack_pulse();
    check_pins("R4");
    check("R4 latch kept", pa_out, 8'h5A);

    // R5 capture into separate latch
    strobe(8'hC3);
    check_pins("R5");
    check("R5 out latch untouched", pa_out, 8'h5A);

    // R7 other lines ignored
    host_write(2'd3, 8'h07);
    host_write(2'd3, 8'h03);
    check_status("R7 line 3 ignored");

    // R7/R8 input enable
    host_write(2'd3, 8'h09); m_ie_in = 1'b1;
    check_pins("R8 input intr");
    check_status("R9 enables");

    // R11 overwrite while full, R6 read clears
    strobe(8'h3C);
    check_pins("R11 ibf stays");
    take_byte("R6/R11 input byte");
    check_pins("R6 cleared");

    // R8 output side interrupt
    host_write(2'd3, 8'h0D); m_ie_out = 1'b1;
    check_pins("R8 done intr");
    send_byte(8'hA5);
    check_pins("R8 write clears");
    ack_pulse();
    check_pins("R8 ack intr");

    // R7 clear input enable
    host_write(2'd3, 8'h08); m_ie_in = 1'b0;
    check_status("R7 clear input enable");

    // R10 mode word clears everything
    strobe(8'h66);
    send_byte(8'h99);
    void'(out_q.pop_front());
    host_write(2'd3, 8'hC0);
    m_ie_out = 1'b0; m_ie_in = 1'b0; m_ibf = 1'b0; m_obf_n = 1'b1; m_done = 1'b0;
    void'(in_q.pop_front());
    check_pins("R10");
    check_status("R10 status");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule